// File: doc/BRIEF.md
# Data-Enable-Only Flat Panel Timing Generator

This block drives the pixel-clock-domain control of a flat panel that needs only a data-enable (DE) line to find its pixels. A horizontal counter advances on every pixel clock. A vertical counter advances once per line. DE goes high while both counters sit inside the active area. The current column and row are presented alongside DE, so an upstream pixel source can return RGB data for that coordinate.

The panel has no sync pulses to rely on, so the two sync outputs stay low permanently. The front porch, sync slot and back porch of each axis are still parameters. They set how long DE stays low: a short gap between lines and a much longer gap between frames, which is how the panel tells the two apart. A start-of-line strobe marks the first pixel of each line, and a start-of-frame strobe marks the first pixel of row 0. The defaults give an 800 by 600 raster. A 1024 by 768 raster is obtained by overriding the parameters.

Each axis is a four-state machine that cycles through the states ACTIVE, FRONT, SYNC and BACK. It stays in each state for the parameterised number of steps. The transitions are ACTIVE->FRONT, FRONT->SYNC, SYNC->BACK and BACK->ACTIVE, and each one is taken when the state's count expires. The horizontal machine steps every clock. The vertical machine steps when the horizontal machine leaves BACK. Reset puts both machines at the first step of BACK.

Top module: `de_panel_timing`

## Requirements
- R1: While reset is high and in the cycle after it, de, sof and sol are 0 and x and y are 0. After reset is released, both axes start at the beginning of their back porch. The first de=1 therefore appears H_BP + (V_BP-1)*HT + 1 clocks after release, where HT = H_ACTIVE+H_FP+H_SW+H_BP.
- R2: de is high for exactly H_ACTIVE consecutive clocks per line, on V_ACTIVE lines per frame.
- R3: While de is high, x counts 0,1,...,H_ACTIVE-1 along the line. y is constant within a line and is 0 on the first active line of a frame, rising by 1 on each following line.
- R4: While de is low, x and y read 0.
- R5: sol is a one-clock pulse that coincides with x=0 and de=1 on every active line.
- R6: sof is a one-clock pulse that coincides with x=0, y=0 and de=1, and occurs exactly once per frame of HT*(V_ACTIVE+V_FP+V_SW+V_BP) clocks.
- R7: Between lines of one frame, de stays low for H_FP+H_SW+H_BP clocks. Between frames it stays low for (V_FP+V_SW+V_BP)*HT + H_FP+H_SW+H_BP clocks.
- R8: hsync and vsync are 0 in every cycle.
- R9: With default parameters (800x600, horizontal 128/1/128, vertical 28/1/28), the first de=1 comes 28668 clocks after reset release, and the next line starts 1057 clocks later with y=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| de | output | 1 | Data enable, high on active pixels |
| x | output | XW | Active column, 0 when de is low |
| y | output | YW | Active row, 0 when de is low |
| sof | output | 1 | Start-of-frame strobe |
| sol | output | 1 | Start-of-line strobe |
| hsync | output | 1 | Horizontal sync, held low |
| vsync | output | 1 | Vertical sync, held low |

## Verification
On every cycle, the assertions check the following at the ports: the length of each DE-high run and of each DE-low gap, the step of x within a line, the hold of y within a line, the zeroed coordinates during blanking, and the alignment of the strobes with the first pixel. Only the bench scenarios can show the items that depend on counting from reset or across a whole frame: the exact cycle of the first pixel after reset, the row sequence across a frame, one sof per frame, restart after a mid-frame reset, and the default 800x600 line timing.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ptg_axis.sv
module ptg_axis
    import ptg_pkg::*;
#(
    parameter int ACT = 800,
    parameter int FP  = 128,
    parameter int SW  = 1,
    parameter int BP  = 128,
    parameter int CW  = $clog2(max4(ACT, FP, SW, BP) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output seg_e          seg,
    output logic [CW-1:0] pos,
    output logic          wrap
);

    seg_e          seg_q, seg_d;
    logic [CW-1:0] pos_q, pos_d;
    logic [CW-1:0] last_pos;
    logic          at_last;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= SEG_BACK;
            pos_q <= '0;
        end else begin
            seg_q <= seg_d;
            pos_q <= pos_d;
        end
    end

    // segment length and next state
    always_comb begin
        last_pos = '0;
        unique case (seg_q)
            SEG_ACTIVE: last_pos = CW'(ACT - 1);
            SEG_FRONT:  last_pos = CW'(FP - 1);
            SEG_SYNC:   last_pos = CW'(SW - 1);
            SEG_BACK:   last_pos = CW'(BP - 1);
            default:    last_pos = '0;
        endcase
        at_last = (pos_q == last_pos);

        seg_d = seg_q;
        pos_d = pos_q;
        if (adv) begin
            if (at_last) begin
                pos_d = '0;
                unique case (seg_q)
                    SEG_ACTIVE: seg_d = SEG_FRONT;
                    SEG_FRONT:  seg_d = SEG_SYNC;
                    SEG_SYNC:   seg_d = SEG_BACK;
                    SEG_BACK:   seg_d = SEG_ACTIVE;
                    default:    seg_d = SEG_BACK;
                endcase
            end else begin
                pos_d = pos_q + CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        seg  = seg_q;
        pos  = pos_q;
        wrap = adv && at_last && (seg_q == SEG_BACK);
    end

endmodule

// File: rtl/ptg_drive.sv
module ptg_drive
    import ptg_pkg::*;
#(
    parameter int HCW = 10,
    parameter int VCW = 10,
    parameter int XW  = 10,
    parameter int YW  = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  seg_e           h_seg,
    input  seg_e           v_seg,
    input  logic [HCW-1:0] h_pos,
    input  logic [VCW-1:0] v_pos,
    output logic           de,
    output logic [XW-1:0]  x,
    output logic [YW-1:0]  y,
    output logic           sof,
    output logic           sol
);

    logic in_area;
    logic first_px;

    always_comb begin
        in_area  = (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);
        first_px = in_area && (h_pos == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            de  <= 1'b0;
            x   <= '0;
            y   <= '0;
            sof <= 1'b0;
            sol <= 1'b0;
        end else begin
            de  <= in_area;
            x   <= in_area ? h_pos[XW-1:0] : '0;
            y   <= in_area ? v_pos[YW-1:0] : '0;
            sol <= first_px;
            sof <= first_px && (v_pos == '0);
        end
    end

endmodule

// File: rtl/de_panel_timing.sv
module de_panel_timing
    import ptg_pkg::*;
#(
    parameter int H_ACTIVE = 800,
    parameter int H_FP     = 128,
    parameter int H_SW     = 1,
    parameter int H_BP     = 128,
    parameter int V_ACTIVE = 600,
    parameter int V_FP     = 28,
    parameter int V_SW     = 1,
    parameter int V_BP     = 28,
    parameter int XW       = $clog2(H_ACTIVE),
    parameter int YW       = $clog2(V_ACTIVE)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          de,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          sof,
    output logic          sol,
    output logic          hsync,
    output logic          vsync
);

    localparam int HCW = $clog2(max4(H_ACTIVE, H_FP, H_SW, H_BP) + 1);
    localparam int VCW = $clog2(max4(V_ACTIVE, V_FP, V_SW, V_BP) + 1);

    seg_e           h_seg, v_seg;
    logic [HCW-1:0] h_pos;
    logic [VCW-1:0] v_pos;
    logic           h_wrap;
    logic           v_wrap;

    ptg_axis #(.ACT(H_ACTIVE), .FP(H_FP), .SW(H_SW), .BP(H_BP), .CW(HCW)) u_hor (
        .clk  (clk),
        .rst  (rst),
        .adv  (1'b1),
        .seg  (h_seg),
        .pos  (h_pos),
        .wrap (h_wrap)
    );

    ptg_axis #(.ACT(V_ACTIVE), .FP(V_FP), .SW(V_SW), .BP(V_BP), .CW(VCW)) u_ver (
        .clk  (clk),
        .rst  (rst),
        .adv  (h_wrap),
        .seg  (v_seg),
        .pos  (v_pos),
        .wrap (v_wrap)
    );

    ptg_drive #(.HCW(HCW), .VCW(VCW), .XW(XW), .YW(YW)) u_drv (
        .clk   (clk),
        .rst   (rst),
        .h_seg (h_seg),
        .v_seg (v_seg),
        .h_pos (h_pos),
        .v_pos (v_pos),
        .de    (de),
        .x     (x),
        .y     (y),
        .sof   (sof),
        .sol   (sol)
    );

    // the panel finds frame edges from DE gap length alone
    assign hsync = 1'b0;
    assign vsync = 1'b0;

    logic unused_wrap;
    assign unused_wrap = v_wrap;

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
    parameter int H_ACTIVE = 800,
    parameter int H_FP     = 128,
    parameter int H_SW     = 1,
    parameter int H_BP     = 128,
    parameter int V_FP     = 28,
    parameter int V_SW     = 1,
    parameter int V_BP     = 28,
    parameter int XW       = 10,
    parameter int YW       = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          de,
    input logic [XW-1:0] x,
    input logic [YW-1:0] y,
    input logic          sof,
    input logic          sol
);

    localparam int HBLANK = H_FP + H_SW + H_BP;
    localparam int HTOT   = H_ACTIVE + HBLANK;
    localparam int VGAP   = (V_FP + V_SW + V_BP) * HTOT + HBLANK;

    logic        prev_de;
    logic [31:0] run;
    logic        seen_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_de   <= 1'b0;
            run       <= '0;
            seen_fall <= 1'b0;
        end else begin
            prev_de   <= de;
            run       <= (de != prev_de) ? 32'd1 : run + 32'd1;
            seen_fall <= seen_fall | (prev_de && !de);
        end
    end

    AST_ACTIVE_RUN: assert property (@(posedge clk) disable iff (rst)
        (prev_de && !de) |-> (run == 32'(H_ACTIVE))); // R2

    AST_GAP_LEN: assert property (@(posedge clk) disable iff (rst)
        (de && !prev_de && seen_fall) |-> (run == 32'(HBLANK) || run == 32'(VGAP))); // R7

    AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
        (de && prev_de) |-> (x == $past(x) + XW'(1))); // R3

    AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
        (de && prev_de) |-> (y == $past(y))); // R3

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        !de |-> (x == '0 && y == '0)); // R4

    AST_SOL_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (de && !prev_de) |-> (sol && x == '0)); // R5

    AST_SOL_ONLY_FIRST: assert property (@(posedge clk) disable iff (rst)
        sol |-> (de && !prev_de)); // R5

    AST_SOF_ALIGN: assert property (@(posedge clk) disable iff (rst)
        sof |-> (sol && de && y == '0)); // R6

endmodule

bind de_panel_timing ptg_checker #(
    .H_ACTIVE (H_ACTIVE),
    .H_FP     (H_FP),
    .H_SW     (H_SW),
    .H_BP     (H_BP),
    .V_FP     (V_FP),
    .V_SW     (V_SW),
    .V_BP     (V_BP),
    .XW       (XW),
    .YW       (YW)
) u_chk (
    .clk (clk),
    .rst (rst),
    .de  (de),
    .x   (x),
    .y   (y),
    .sof (sof),
    .sol (sol)
);

// File: tb/tb_de_panel_timing.sv
module tb_de_panel_timing;

    // small raster: 8x4 active, h 3/1/2, v 2/1/2 -> HT=14, 9 lines, 126 clocks
    localparam int SHA = 8, SHF = 3, SHS = 1, SHB = 2;
    localparam int SVA = 4, SVF = 2, SVS = 1, SVB = 2;
    localparam int SHT = SHA + SHF + SHS + SHB;
    localparam int SFT = SHT * (SVA + SVF + SVS + SVB);
    localparam int SD  = SHB + (SVB - 1) * SHT;

    // {cycle after reset release, de, sof, sol, x, y}
    localparam int NV = 11;
    localparam int VEC [NV][6] = '{
        '{  1, 0, 0, 0, 0, 0},
        '{ 16, 0, 0, 0, 0, 0},
        '{ 17, 1, 1, 1, 0, 0},
        '{ 18, 1, 0, 0, 1, 0},
        '{ 24, 1, 0, 0, 7, 0},
        '{ 25, 0, 0, 0, 0, 0},
        '{ 31, 1, 0, 1, 0, 1},
        '{ 62, 1, 0, 0, 3, 3},
        '{ 73, 0, 0, 0, 0, 0},
        '{142, 0, 0, 0, 0, 0},
        '{143, 1, 1, 1, 0, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       de, sof, sol, hs, vs;
    logic [9:0] x, y;
    logic       sde, ssof, ssol, shs, svs;
    logic [2:0] sx;
    logic [1:0] sy;

    de_panel_timing dut (
        .clk(clk), .rst(rst), .de(de), .x(x), .y(y),
        .sof(sof), .sol(sol), .hsync(hs), .vsync(vs)
    );

    de_panel_timing #(
        .H_ACTIVE(SHA), .H_FP(SHF), .H_SW(SHS), .H_BP(SHB),
        .V_ACTIVE(SVA), .V_FP(SVF), .V_SW(SVS), .V_BP(SVB)
    ) dut_s (
        .clk(clk), .rst(rst), .de(sde), .x(sx), .y(sy),
        .sof(ssof), .sol(ssol), .hsync(shs), .vsync(svs)
    );

    int checks = 0;
    int fails  = 0;
    int n      = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, n, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n = 0;
    endtask

    task automatic go_to(input int target);
        while (n < target) begin
            @(posedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    // expected small-raster outputs, from the requirement arithmetic
    task automatic model(input int c, output int e_de, output int e_sof, output int e_sol,
                         output int e_x, output int e_y);
        int f, ln, col;
        f     = (c - 1 + SFT - SD) % SFT;
        ln    = f / SHT;
        col   = f % SHT;
        e_de  = (c >= 1 && ln < SVA && col < SHA) ? 1 : 0;
        e_x   = e_de ? col : 0;
        e_y   = e_de ? ln : 0;
        e_sol = (e_de && col == 0) ? 1 : 0;
        e_sof = (e_sol && ln == 0) ? 1 : 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: values during reset
        repeat (2) @(negedge clk);
        chk("R1", "de in reset", sde, 0);
        chk("R1", "x/y in reset", int'(sx) + int'(sy), 0);
        chk("R1", "sof/sol in reset", int'(ssof) + int'(ssol), 0);
        do_reset();

        // table walk on the small raster
        for (int i = 0; i < NV; i++) begin
            go_to(VEC[i][0]);
            chk("R1/R2", "de",  sde,  VEC[i][1]);
            chk("R6",    "sof", ssof, VEC[i][2]);
            chk("R5",    "sol", ssol, VEC[i][3]);
            chk("R3/R4", "x",   sx,   VEC[i][4]);
            chk("R3/R4", "y",   sy,   VEC[i][5]);
        end

        // full sweep of more than two frames
        do_reset();
        begin
            int sof_cnt = 0;
            int bad = 0;
            for (int c = 1; c <= 2 * SFT + 48; c++) begin
                int e_de, e_sof, e_sol, e_x, e_y;
                go_to(c);
                model(c, e_de, e_sof, e_sol, e_x, e_y);
                if (ssof) sof_cnt++;
                if (sde != e_de || ssof != e_sof || ssol != e_sol ||
                    int'(sx) != e_x || int'(sy) != e_y) begin
                    bad++;
                    $display("FAIL R2/R7 sweep cycle %0d: actual de=%0d x=%0d y=%0d sol=%0d sof=%0d expected de=%0d x=%0d y=%0d sol=%0d sof=%0d",
                             c, sde, sx, sy, ssol, ssof, e_de, e_x, e_y, e_sol, e_sof);
                end
                if (shs || svs || hs || vs) begin
                    bad++;
                    $display("FAIL R8 sync high at cycle %0d: actual %0d%0d%0d%0d expected 0000", c, shs, svs, hs, vs);
                end
            end
            checks++;
            fails += (bad != 0) ? 1 : 0;
            chk("R6", "sof count in three frame starts", sof_cnt, 3);
        end

        // mid-frame reset restarts at the back porch (R1)
        go_to(2 * SFT + 60);
        do_reset();
        go_to(SD);
        chk("R1", "de before first pixel after re-reset", sde, 0);
        go_to(SD + 1);
        chk("R1", "de at first pixel after re-reset", sde, 1);
        chk("R1", "sof at first pixel after re-reset", ssof, 1);

        // default 800x600 raster (R9)
        do_reset();
        go_to(28667);
        chk("R9", "default de before first pixel", de, 0);
        go_to(28668);
        chk("R9", "default first de", de, 1);
        chk("R9", "default sof", sof, 1);
        chk("R9", "default x at first pixel", x, 0);
        go_to(28668 + 799);
        chk("R2", "default last pixel de", de, 1);
        chk("R3", "default last x", x, 799);
        go_to(28668 + 800);
        chk("R2", "default de after 800", de, 0);
        chk("R4", "default x in blank", x, 0);
        go_to(28668 + 1056);
        chk("R7", "default de end of hblank", de, 0);
        go_to(28668 + 1057);
        chk("R9", "default second line de", de, 1);
        chk("R9", "default second line y", y, 1);
        chk("R5", "default second line sol", sol, 1);
        chk("R6", "default second line sof", sof, 0);
        chk("R8", "default syncs", int'(hs) + int'(vs), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule